// File: doc/BRIEF.md
# Shift-and-Store Serial-to-Parallel Register

This block turns a serial bit stream into a parallel byte. A chain of eight flip-flop stages takes one new bit from the serial input on every rising clock edge, and every stage moves its bit one place further along the chain. Each stage has its own level-sensitive storage latch. While the strobe is high the latches follow the chain. When the strobe goes low the latches hold their value, so the parallel outputs stay steady while the next word is shifted in behind them.

The parallel outputs go through an output stage controlled by an enable input. There are no internal tri-state buffers. A per-bit drive-enable vector goes out next to the data, and the integrating level can use it to build a shared-bus driver. The data lines are forced to zero while the outputs are off.

Two cascade outputs carry the last stage to a following register. The fast output changes right after the rising edge. The slow output repeats the same bit half a period later, on the falling edge, which gives a downstream device extra hold margin when clock edges are slow. Neither the strobe nor the output enable affects the serial path. The block has no reset, so the stages are undefined until eight bits have been clocked in.

Top module: `ssr_top`

## Requirements
- R1: On every rising `clk` edge, stage 0 takes `ser_in` and each stage k (1 to 7) takes the value stage k-1 held before the edge.
- R2: Parallel bit k (`par_data[k]`) comes from stage k. After eight clocks, the first bit shifted in is at bit 7 and the last one is at bit 0.
- R3: While `strobe` is high, the storage latches are transparent. With `out_en` high, `par_data` follows the stages after every rising edge.
- R4: With `out_en` high, `par_drive` is all ones and `par_data` shows the latch contents. With `out_en` low, `par_drive` and `par_data` are both all zeros.
- R5: `casc_fast` equals stage 7 and changes only on the rising `clk` edge.
- R6: `casc_slow` takes the value of stage 7 on each falling `clk` edge and holds it until the next falling edge.
- R7: While `strobe` stays low, rising clock edges change the stages and the cascade outputs but leave `par_data` unchanged.
- R8: `strobe` and `out_en` have no effect on the shift stages or on either cascade output. Shifting carries on while the parallel outputs are off.
- R9: When a second register takes its serial input from `casc_fast`, or from `casc_slow`, of the first, the two registers together hold the last 16 bits clocked in. The downstream register holds the older eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the stages move on the rising edge |
| ser_in | input | 1 | Serial data input to stage 0 |
| strobe | input | 1 | High: storage latches transparent; low: latches hold |
| out_en | input | 1 | Output enable for the parallel bus |
| par_data | output | 8 | Stored word, zero while disabled |
| par_drive | output | 8 | Per-bit drive enable (all ones when enabled) |
| casc_fast | output | 1 | Stage 7, updated on the rising edge |
| casc_slow | output | 1 | Stage 7, re-timed to the falling edge |

## Verification
The hardest state to reach is the one where the stages and the latches hold different values: new bits sit in the chain while the parallel outputs still show an older word. With no reset, this state can only be built by clocking in a full word first. The stimulus therefore shifts a known 16-bit word through two chained registers and raises the strobe. It then drops the strobe and shifts more bits, and also shifts with the outputs turned off, before it compares the outputs. A sweep then loads every 8-bit value in turn and compares both the upstream word and the downstream word against a bit history kept in the bench.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    // Default chain length of the shift-and-store register.
    localparam int unsigned SSR_STAGES_DEFAULT = 8;
endpackage

// File: rtl/ssr_shift_core.sv
module ssr_shift_core #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input  logic              clk,
    input  logic              ser_in,
    output logic [STAGES-1:0] stages_q,
    output logic              casc_fast,
    output logic              casc_slow
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } shift_t;

    shift_t shift_d, shift_q;
    logic   slow_q;

    // Next-state: everything moves one place toward the last stage.
    always_comb begin
        shift_d       = shift_q;
        shift_d.chain = {shift_q.chain[LAST-1:0], ser_in};
    end

    always_ff @(posedge clk) begin
        shift_q <= shift_d;
    end

    // Half-cycle re-timing of the last stage for slow-edge cascading.
    always_ff @(negedge clk) begin
        slow_q <= shift_q.chain[LAST];
    end

    assign stages_q  = shift_q.chain;
    assign casc_fast = shift_q.chain[LAST];
    assign casc_slow = slow_q;
endmodule

// File: rtl/ssr_store_bank.sv
module ssr_store_bank #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input  logic              strobe,
    input  logic [STAGES-1:0] stages_q,
    output logic [STAGES-1:0] held_q
);
    // One level-sensitive latch per stage, open while strobe is high.
    for (genvar k = 0; k < STAGES; k++) begin : g_latch
        always_latch begin
            if (strobe) begin
                held_q[k] = stages_q[k];
            end
        end
    end
endmodule

// File: rtl/ssr_bus_drive.sv
module ssr_bus_drive #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input  logic              out_en,
    input  logic [STAGES-1:0] held_q,
    output logic [STAGES-1:0] par_data,
    output logic [STAGES-1:0] par_drive
);
    for (genvar k = 0; k < STAGES; k++) begin : g_bit
        always_comb begin
            par_drive[k] = out_en;
            par_data[k]  = out_en & held_q[k];
        end
    end
endmodule

// File: rtl/ssr_top.sv
module ssr_top #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input  logic              clk,
    input  logic              ser_in,
    input  logic              strobe,
    input  logic              out_en,
    output logic [STAGES-1:0] par_data,
    output logic [STAGES-1:0] par_drive,
    output logic              casc_fast,
    output logic              casc_slow
);
    logic [STAGES-1:0] stages_q;
    logic [STAGES-1:0] held_q;

    ssr_shift_core #(.STAGES(STAGES)) i_core (
        .clk       (clk),
        .ser_in    (ser_in),
        .stages_q  (stages_q),
        .casc_fast (casc_fast),
        .casc_slow (casc_slow)
    );

    ssr_store_bank #(.STAGES(STAGES)) i_store (
        .strobe   (strobe),
        .stages_q (stages_q),
        .held_q   (held_q)
    );

    ssr_bus_drive #(.STAGES(STAGES)) i_drive (
        .out_en    (out_en),
        .held_q    (held_q),
        .par_data  (par_data),
        .par_drive (par_drive)
    );
endmodule

// File: rtl/ssr_chk.sv
module ssr_chk #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input logic              clk,
    input logic              ser_in,
    input logic              strobe,
    input logic              out_en,
    input logic [STAGES-1:0] par_data,
    input logic [STAGES-1:0] par_drive,
    input logic              casc_fast,
    input logic              casc_slow,
    input logic [STAGES-1:0] stages_q
);
    // No reset exists: checks wait until the chain has been filled.
    int unsigned warm_q = 0;
    logic        cold;

    always_ff @(posedge clk) begin
        if (warm_q < 2 * STAGES + 2) warm_q <= warm_q + 1;
    end
    assign cold = (warm_q < 2 * STAGES + 2);

    AST_STAGE0_TAKES_INPUT: assert property (@(posedge clk) disable iff (cold)
        1'b1 |=> (stages_q[0] == $past(ser_in)));                      // R1
    AST_CHAIN_ADVANCES: assert property (@(posedge clk) disable iff (cold)
        1'b1 |=> (stages_q[STAGES-1:1] == $past(stages_q[STAGES-2:0]))); // R1
    AST_FAST_TAP: assert property (@(posedge clk) disable iff (cold)
        1'b1 |=> (casc_fast == $past(stages_q[STAGES-2])));             // R5
    AST_SLOW_LAGS: assert property (@(negedge clk) disable iff (cold)
        1'b1 |=> (casc_slow == $past(casc_fast)));                       // R6
    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (cold)
        (strobe && out_en) |-> (par_data == stages_q));                 // R3
    AST_OFF_BUS: assert property (@(posedge clk) disable iff (cold)
        !out_en |-> (par_drive == '0 && par_data == '0));               // R4
    AST_ON_BUS: assert property (@(posedge clk) disable iff (cold)
        out_en |-> (par_drive == '1));                                  // R4
    AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (cold)
        (!strobe && !$past(strobe) && out_en && $past(out_en)) |-> $stable(par_data)); // R7
endmodule

bind ssr_top ssr_chk #(.STAGES(STAGES)) i_ssr_chk (
    .clk       (clk),
    .ser_in    (ser_in),
    .strobe    (strobe),
    .out_en    (out_en),
    .par_data  (par_data),
    .par_drive (par_drive),
    .casc_fast (casc_fast),
    .casc_slow (casc_slow),
    .stages_q  (stages_q)
);

// File: tb/test_ssr_top.sv
`timescale 1ns/1ps
module test_ssr_top;
    logic       clk = 1'b0;
    logic       ser_in = 1'b0;
    logic       strobe = 1'b0;
    logic       out_en = 1'b1;
    logic [7:0] par_a, drv_a, par_f, drv_f, par_s, drv_s;
    logic       fast_a, slow_a, fast_f, slow_f, fast_s, slow_s;
    logic [15:0] hist = '0;   // bench model: hist[k] = bit clocked k+1 edges ago
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;    // 50 MHz

    always @(posedge clk) hist <= {hist[14:0], ser_in};

    ssr_top i_ssr_top (.clk(clk), .ser_in(ser_in), .strobe(strobe), .out_en(out_en),
        .par_data(par_a), .par_drive(drv_a), .casc_fast(fast_a), .casc_slow(slow_a));
    ssr_top i_ssr_top_f (.clk(clk), .ser_in(fast_a), .strobe(strobe), .out_en(out_en),
        .par_data(par_f), .par_drive(drv_f), .casc_fast(fast_f), .casc_slow(slow_f));
    ssr_top i_ssr_top_s (.clk(clk), .ser_in(slow_a), .strobe(strobe), .out_en(out_en),
        .par_data(par_s), .par_drive(drv_s), .casc_fast(fast_s), .casc_slow(slow_s));

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk) ser_in = b;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] pat;
        logic [7:0]  snap;
        pat = 16'hA5C3;
        // R9 / R2: 16 bits through two chained registers, strobe closed
        for (int i = 15; i >= 0; i--) shift_bit(pat[i]);
        @(negedge clk) strobe = 1'b1;
        #2;
        check8("R2 upstream word", par_a, pat[7:0]);
        check8("R9 fast-chained downstream word", par_f, pat[15:8]);
        check8("R9 slow-chained downstream word", par_s, pat[15:8]);
        check8("R4 drive on", drv_a, 8'hFF);

        // R3: transparent latch follows each shift
        shift_bit(1'b1);
        check8("R3 transparent follow", par_a, hist[7:0]);
        shift_bit(1'b0);
        check8("R3 transparent follow 2", par_a, hist[7:0]);

        // R7: strobe low holds the word while shifting continues
        @(negedge clk) strobe = 1'b0;
        snap = hist[7:0];
        shift_bit(1'b1);
        shift_bit(1'b1);
        shift_bit(1'b0);
        check8("R7 held while closed", par_a, snap);
        check8("R5 fast tap is stage 7", {7'd0, fast_a}, {7'd0, hist[7]});

        // R6: slow output lags to the falling edge
        for (int i = 0; i < 4; i++) begin
            shift_bit(i[0]);
            check8("R6 slow before fall", {7'd0, slow_a}, {7'd0, hist[8]});
            check8("R5 fast after rise", {7'd0, fast_a}, {7'd0, hist[7]});
            @(negedge clk);
            #2;
            check8("R6 slow after fall", {7'd0, slow_a}, {7'd0, hist[7]});
        end

        // R4 / R8: outputs off, serial path keeps going
        @(negedge clk) out_en = 1'b0;
        #2;
        check8("R4 drive off", drv_a, 8'h00);
        check8("R4 data off", par_a, 8'h00);
        for (int i = 7; i >= 0; i--) begin
            shift_bit(8'h5A >> i);
            check8("R8 serial runs while off", {7'd0, fast_a}, {7'd0, hist[7]});
        end
        @(negedge clk) begin strobe = 1'b1; out_en = 1'b1; end
        #2;
        check8("R8 stages advanced while off", par_a, hist[7:0]);
        check8("R8 downstream advanced while off", par_f, hist[15:8]);

        // R1 / R9: exhaustive byte sweep
        for (int v = 0; v < 256; v++) begin
            @(negedge clk) strobe = 1'b0;
            for (int i = 7; i >= 0; i--) shift_bit(v[i]);
            @(negedge clk) strobe = 1'b1;
            #2;
            check8("R1 sweep upstream", par_a, v[7:0]);
            check8("R9 sweep fast chain", par_f, hist[15:8]);
            check8("R9 sweep slow chain", par_s, hist[15:8]);
        end
        finish_run();
    end
endmodule